// File: doc/BRIEF.md
# Rewindable FIFO with Half-Full Flag

This block is a single-clock first-in first-out buffer for 9-bit words. Its depth is a parameter and must be a power of two, for example from 512 up to 16384 words. A write strobe and a read strobe act as per-cycle enables. The block drives three active-low status flags: empty, full and more-than-half-full.

The read port is show-ahead. The oldest stored word is always present on the data output while the buffer is not empty, and a read strobe moves on to the next word. A rewind input returns the read position to the first storage location and leaves the write position where it is. Everything written since reset can then be read again without being written a second time. The rewind is meaningful only while no more than DEPTH words have been written since reset.

Two boundary cases work with single-cycle turnaround:
- A word written into an empty buffer can be read on the next cycle.
- A word read from a full buffer frees a slot that the next write can use at once.

Top module: `rtx_fifo`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the flags are empty_n=0, full_n=1 and half_n=1, and both positions are at location zero.
- R2: A write with full_n=1 stores din and advances the write position. A write with full_n=0 is ignored: no stored word changes and no position moves.
- R3: A read with empty_n=1 and rtx=0 advances the read position. A read with empty_n=0 is ignored.
- R4: While empty_n=1, dout shows the oldest unread word, and words come out in the order they were written.
- R5: empty_n is 0 exactly when the stored count is 0. full_n is 0 exactly when the count equals DEPTH. Both flags are registered and reflect the count after the previous edge.
- R6: half_n is 0 exactly when the count is greater than DEPTH/2. It is 1 at a count of DEPTH/2 or less.
- R7: A cycle with rtx=1 sets the read position to zero and ignores any read in that cycle. A write in that cycle still proceeds. The count then becomes the write position, and the words from location zero onward are read again.
- R8: A read and a write in the same cycle, with the buffer neither empty nor full, leave the count unchanged.
- R9: One cycle after a word is written into an empty buffer, empty_n=1 and dout shows that word. After that word is read, empty_n returns to 0.
- R10: One cycle after a read from a full buffer, full_n=1. A write on that cycle is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rtx | input | 1 | Rewind read position to location zero |
| din | input | 9 | Write data |
| dout | output | 9 | Oldest unread word (show-ahead) |
| empty_n | output | 1 | Low when the buffer holds no words |
| full_n | output | 1 | Low when the buffer holds DEPTH words |
| half_n | output | 1 | Low when the buffer holds more than DEPTH/2 words |

## Verification
A read position that moves wrongly shows up on dout on the very next cycle, because the output is show-ahead and the bench compares it against a queue model on every clock. A wrong count or flag register shows up one edge after the event that caused it, through a flag disagreeing with the model's count. A missed or duplicated write stays hidden until that location is read. For that reason the bench drains the buffer after each full and rewind scenario, so that every stored word passes the output at least once.

// File: rtl/rtxf_pkg.sv
package rtxf_pkg;
  // Number of stored words from extended pointers of width pw
  function automatic int unsigned fill_of(input int unsigned wp,
                                          input int unsigned rp,
                                          input int unsigned pw);
    int unsigned mask;
    mask = (32'd1 << pw) - 32'd1;
    return (wp - rp) & mask;
  endfunction

  // True when the fill exceeds half of the capacity
  function automatic logic over_half(input int unsigned fill,
                                     input int unsigned depth);
    return fill > (depth / 2);
  endfunction
endpackage

// File: rtl/rtxf_ptr.sv
module rtxf_ptr #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] nxt
);
  always_comb begin
    if (clr)       nxt = '0;
    else if (step) nxt = ptr + PW'(1);
    else           nxt = ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= nxt;
  end
endmodule

// File: rtl/rtxf_ram.sv
module rtxf_ram #(
  parameter int DEPTH = 512,
  parameter int DW    = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rtxf_flags.sv
module rtxf_flags #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] nxt_wr,
  input  logic [PW-1:0] nxt_rd,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n
);
  import rtxf_pkg::*;

  int unsigned nfill;
  assign nfill = fill_of(int'(nxt_wr), int'(nxt_rd), PW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_n <= 1'b0;
      full_n  <= 1'b1;
      half_n  <= 1'b1;
    end else begin
      empty_n <= (nfill != 0);
      full_n  <= (nfill != DEPTH);
      half_n  <= !over_half(nfill, DEPTH);
    end
  end
endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo #(
  parameter int DEPTH = 512,
  parameter int DW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          rtx,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n
);
  import rtxf_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  if (DEPTH != (1 << AW)) begin : g_bad_depth
    $error("DEPTH must be a power of two");
  end

  // Named internal events
  logic          wr_go, rd_go;
  logic [PW-1:0] wr_ptr, rd_ptr, nxt_wr, nxt_rd, occ;

  assign wr_go = wr_en & full_n;
  assign rd_go = rd_en & empty_n & ~rtx;
  assign occ   = PW'(fill_of(int'(wr_ptr), int'(rd_ptr), PW));

  rtxf_ptr #(.PW(PW)) u_wp (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .step(wr_go),
    .ptr(wr_ptr), .nxt(nxt_wr)
  );

  rtxf_ptr #(.PW(PW)) u_rp (
    .clk(clk), .rst_n(rst_n), .clr(rtx), .step(rd_go),
    .ptr(rd_ptr), .nxt(nxt_rd)
  );

  rtxf_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk(clk), .we(wr_go), .waddr(wr_ptr[AW-1:0]), .wdata(din),
    .raddr(rd_ptr[AW-1:0]), .rdata(dout)
  );

  rtxf_flags #(.DEPTH(DEPTH)) u_flg (
    .clk(clk), .rst_n(rst_n), .nxt_wr(nxt_wr), .nxt_rd(nxt_rd),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );
endmodule

// File: rtl/rtx_fifo_chk.sv
module rtx_fifo_chk #(
  parameter int DEPTH = 512,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          rtx,
  input logic          empty_n,
  input logic          full_n,
  input logic          half_n,
  input logic          wr_go,
  input logic          rd_go,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic [PW-1:0] occ
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!empty_n && full_n && half_n && wr_ptr == '0 && rd_ptr == '0)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !wr_go); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !rd_go); // R3
  AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    empty_n == (occ != '0)); // R5
  AST_FULL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    full_n == (occ != PW'(DEPTH))); // R5
  AST_HALF_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    half_n == (occ <= PW'(DEPTH / 2))); // R6
  AST_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    rtx |=> (rd_ptr == '0)); // R7
  AST_RW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && rd_go) |=> $stable(occ)); // R8
  AST_FLOW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && wr_en) |=> empty_n); // R9
  AST_FLOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && rd_en && !rtx) |=> full_n); // R10
endmodule

bind rtx_fifo rtx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rtx(rtx),
  .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
  .wr_go(wr_go), .rd_go(rd_go), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .occ(occ)
);

// File: tb/sim_rtx_fifo.sv
module sim_rtx_fifo;
  localparam int DEPTH = 512;
  localparam int DW    = 9;
  localparam int TCLK  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, rtx = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic empty_n, full_n, half_n;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // Reference model: total writes, read index, stored words
  int wc = 0, rc = 0;
  logic [DW-1:0] mdl [DEPTH];

  always #(TCLK/2) clk = ~clk;

  rtx_fifo #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rtx(rtx),
    .din(din), .dout(dout), .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int n;
    n = wc - rc;
    check(empty_n == (n != 0), "R5", {tag, " empty_n"}, int'(empty_n), int'(n != 0));
    check(full_n == (n != DEPTH), "R5", {tag, " full_n"}, int'(full_n), int'(n != DEPTH));
    check(half_n == (n <= DEPTH/2), "R6", {tag, " half_n"}, int'(half_n), int'(n <= DEPTH/2));
    if (n != 0)
      check(dout == mdl[rc % DEPTH], tag, "dout", int'(dout), int'(mdl[rc % DEPTH]));
  endtask

  // Called at a falling edge; applies one cycle and compares at the next falling edge
  task automatic step(input bit w, input bit r, input bit t,
                      input logic [DW-1:0] d, input string tag);
    int n;
    bit wgo, rgo;
    wr_en = w; rd_en = r; rtx = t; din = d;
    n   = wc - rc;
    wgo = w && (n != DEPTH);
    rgo = r && (n != 0) && !t;
    if (wgo) begin
      mdl[wc % DEPTH] = d;
      wc++;
    end
    if (t) rc = 0;
    else if (rgo) rc++;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; rd_en = 0; rtx = 0;
    repeat (2) @(negedge clk);
    check(!empty_n && full_n && half_n, "R1", "flags in reset",
          {29'd0, empty_n, full_n, half_n}, 3);
    rst_n = 1'b1;
    wc = 0; rc = 0;
    @(negedge clk);
    check(!empty_n && full_n && half_n, "R1", "flags after release",
          {29'd0, empty_n, full_n, half_n}, 3);
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // Read while empty is ignored
    step(0, 1, 0, 9'h000, "R3");
    step(0, 1, 0, 9'h000, "R3");

    // Flow-through: write into empty, then read it
    step(1, 0, 0, 9'h1A5, "R9");
    step(0, 1, 0, 9'h000, "R9");
    // Same-cycle write and read while empty: only the write takes effect
    step(1, 1, 0, 9'h0C3, "R9");
    step(0, 1, 0, 9'h000, "R9");

    // Ordering and simultaneous read/write
    for (int i = 0; i < 6; i++) step(1, 0, 0, DW'(9'h040 + i), "R4");
    step(0, 1, 0, 9'h000, "R4");
    for (int i = 0; i < 5; i++) step(1, 1, 0, DW'(9'h100 + i), "R8");

    // Rewind, with a read in the same cycle ignored
    step(0, 1, 1, 9'h000, "R7");
    step(0, 1, 0, 9'h000, "R7");
    // Rewind together with a write
    step(1, 0, 1, 9'h0EE, "R7");
    while (wc != rc) step(0, 1, 0, 9'h000, "R7");

    // Fill to full and test overflow, read-from-full and drain
    do_reset();
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, DW'((i * 37 + 5) % 512), "R2");
    step(1, 0, 0, 9'h1FF, "R2");
    step(1, 0, 0, 9'h1FE, "R2");
    step(1, 1, 0, 9'h1FD, "R10");
    step(1, 0, 0, 9'h055, "R10");
    while (wc != rc) step(0, 1, 0, 9'h000, "R4");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule